// File: doc/BRIEF.md
# Wave Trap Entry and Return Controller

This block manages entry into and return from the trap handler for a single instruction-sequencing context. Each cycle it looks at three trap sources: a request from the host, a software trap instruction that carries an 8-bit immediate, and a single-step trigger that fires after each completed instruction while stepping is enabled. If the context is running and at least one source is active, the block takes exactly one trap. It chooses that trap by fixed priority, packs a 64-bit trap-information word, snapshots the privilege bit and the status bits, raises privilege, and redirects fetch to a programmable handler base address.

While the handler runs, every further trap entry is blocked. A return-from-trap strobe carries a 64-bit word whose low 48 bits are the resume address. The handler computes that address itself, for example the saved PC plus 4 after a software trap, so the trap instruction does not execute a second time. On return the block redirects fetch to that address, restores the saved privilege bit and hands back the saved status bits.

The controller has two states. In `ST_RUN` the context executes normally. In `ST_HANDLER` the handler body executes. Transition `T_ENTER` goes from `ST_RUN` to `ST_HANDLER` when the arbiter reports a cause other than none. Transition `T_RETURN` goes from `ST_HANDLER` to `ST_RUN` on the return strobe. Every other case holds the current state.

Top module: `wave_trap_ctrl`

## Requirements
- R1: After reset the block is in `ST_RUN`: in_handler, priv, redirect and restore_valid are 0, info_word is all zeros, and the handler base equals the RESET_BASE parameter (0 by default).
- R2: info_word is laid out with bit 63 always 0, bits 62:57 holding the rewind amount sampled at entry, bit 56 the host flag, bits 55:48 the trap ID and bits 47:0 the saved PC.
- R3: A software trap saves cur_pc as the PC, uses sw_trap_id as the trap ID, and clears the host flag.
- R4: A host trap saves next_pc with trap ID 0 and sets the host flag. The host flag is 1 for no other cause.
- R5: When step_en and instr_done are both high, a trap is taken that saves next_pc with ID 0 and host flag 0. step_en without instr_done takes no trap.
- R6: When causes coincide, the host request wins over the software trap, and the software trap wins over single-step. Only one entry is taken.
- R7: One cycle after entry, redirect pulses for one cycle with redirect_pc equal to the handler base, priv reads 1 and in_handler reads 1.
- R8: base_wr loads base_wdata as the handler base from the next cycle on. An entry in the same cycle as the write uses the previous base.
- R9: While in the handler, host, software and single-step requests are ignored. info_word and in_handler keep their values until return.
- R10: A return strobe in the handler redirects to rfe_word[47:0] and ignores the upper 16 bits. It restores priv to its value before entry, pulses restore_valid with restore_status equal to status_in as sampled at entry, and clears in_handler.
- R11: A return strobe while running has no effect: no redirect, no restore pulse, and priv is unchanged.
- R12: While running with no trap taken, prv_load sets priv to prv_val. A trap taken in the same cycle wins, and prv_load is ignored in the handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 48 | Address of the current instruction |
| next_pc | input | 48 | Address of the next instruction to execute |
| instr_done | input | 1 | An instruction completed this cycle |
| sw_trap | input | 1 | Software trap instruction strobe |
| sw_trap_id | input | 8 | Immediate of the software trap |
| host_req | input | 1 | Trap request from the host |
| step_en | input | 1 | Single-step enable |
| rewind | input | 6 | PC rewind amount packed into the word |
| status_in | input | 4 | Status bits to snapshot at entry |
| prv_load | input | 1 | Load privilege while running |
| prv_val | input | 1 | Privilege value to load |
| rfe | input | 1 | Return-from-trap strobe |
| rfe_word | input | 64 | Restored word; low 48 bits are the resume PC |
| base_wr | input | 1 | Write the handler base |
| base_wdata | input | 48 | New handler base |
| redirect | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 48 | Fetch target on redirect |
| info_word | output | 64 | Packed trap-information word |
| priv | output | 1 | Current privilege |
| in_handler | output | 1 | Context is inside the handler |
| restore_valid | output | 1 | One-cycle pulse on return |
| restore_status | output | 4 | Status bits saved at entry |

## Verification
The bench makes all three trap sources coincide. A design with a wrong priority would show the wrong host flag, the wrong ID or the wrong saved PC. It also runs a software trap with ID 0, which a design that selects the PC by ID instead of by cause would save as next_pc. The bench writes the base in the same cycle as an entry, and a design that forwards the new value would redirect to it. It raises trap requests inside the handler, and a design that fails to block them would rewrite info_word. It sends return strobes while running, and a design that accepts them would produce stray redirects. It loads privilege before a trap, and a design that does not save it at entry would come back with privilege stuck at 1.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_HOST = 2'd1,
        CAUSE_SOFT = 2'd2,
        CAUSE_STEP = 2'd3
    } cause_e;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_HANDLER = 1'b1
    } state_e;
endpackage

// File: rtl/trap_arb.sv
module trap_arb
    import trap_pkg::*;
(
    input  logic   allow,
    input  logic   host_req,
    input  logic   soft_req,
    input  logic   step_req,
    output cause_e cause
);
    always_comb begin
        cause = CAUSE_NONE;
        if (allow) begin
            if (host_req)      cause = CAUSE_HOST;
            else if (soft_req) cause = CAUSE_SOFT;
            else if (step_req) cause = CAUSE_STEP;
        end
    end
endmodule

// File: rtl/trap_pack.sv
module trap_pack
    import trap_pkg::*;
#(
    parameter int PC_W = 48,
    parameter int ID_W = 8,
    parameter int RW_W = 6,
    localparam int WORD_W = 1 + RW_W + 1 + ID_W + PC_W
) (
    input  cause_e            cause,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   next_pc,
    input  logic [ID_W-1:0]   soft_id,
    input  logic [RW_W-1:0]   rewind,
    output logic [WORD_W-1:0] word
);
    logic            host_bit;
    logic [ID_W-1:0] id_sel;
    logic [PC_W-1:0] pc_sel;

    always_comb begin
        host_bit = 1'b0;
        id_sel   = '0;
        pc_sel   = next_pc;
        unique case (cause)
            CAUSE_HOST: host_bit = 1'b1;
            CAUSE_SOFT: begin
                id_sel = soft_id;
                pc_sel = cur_pc;
            end
            CAUSE_STEP, CAUSE_NONE: ;
        endcase
        word = {1'b0, rewind, host_bit, id_sel, pc_sel};
    end
endmodule

// File: rtl/trap_base_reg.sv
module trap_base_reg #(
    parameter int PC_W = 48,
    parameter logic [PC_W-1:0] RESET_BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [PC_W-1:0] wdata,
    output logic [PC_W-1:0] base
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  base <= RESET_BASE;
        else if (wr) base <= wdata;
    end
endmodule

// File: rtl/wave_trap_ctrl.sv
module wave_trap_ctrl
    import trap_pkg::*;
#(
    parameter int PC_W = 48,
    parameter int ID_W = 8,
    parameter int RW_W = 6,
    parameter int ST_W = 4,
    parameter logic [PC_W-1:0] RESET_BASE = '0,
    localparam int WORD_W = 1 + RW_W + 1 + ID_W + PC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   next_pc,
    input  logic              instr_done,
    input  logic              sw_trap,
    input  logic [ID_W-1:0]   sw_trap_id,
    input  logic              host_req,
    input  logic              step_en,
    input  logic [RW_W-1:0]   rewind,
    input  logic [ST_W-1:0]   status_in,
    input  logic              prv_load,
    input  logic              prv_val,
    input  logic              rfe,
    input  logic [WORD_W-1:0] rfe_word,
    input  logic              base_wr,
    input  logic [PC_W-1:0]   base_wdata,
    output logic              redirect,
    output logic [PC_W-1:0]   redirect_pc,
    output logic [WORD_W-1:0] info_word,
    output logic              priv,
    output logic              in_handler,
    output logic              restore_valid,
    output logic [ST_W-1:0]   restore_status
);
    state_e            state_q, state_d;
    cause_e            cause;
    logic [PC_W-1:0]   base_q;
    logic [WORD_W-1:0] pack_word;
    logic              saved_priv;

    trap_base_reg #(.PC_W(PC_W), .RESET_BASE(RESET_BASE)) u_base (
        .clk(clk), .rst_n(rst_n), .wr(base_wr), .wdata(base_wdata), .base(base_q)
    );

    trap_arb u_arb (
        .allow(state_q == ST_RUN),
        .host_req(host_req),
        .soft_req(sw_trap),
        .step_req(step_en & instr_done),
        .cause(cause)
    );

    trap_pack #(.PC_W(PC_W), .ID_W(ID_W), .RW_W(RW_W)) u_pack (
        .cause(cause), .cur_pc(cur_pc), .next_pc(next_pc),
        .soft_id(sw_trap_id), .rewind(rewind), .word(pack_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Transitions: T_ENTER (run -> handler), T_RETURN (handler -> run)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (cause != CAUSE_NONE) state_d = ST_HANDLER;
            ST_HANDLER: if (rfe)                 state_d = ST_RUN;
        endcase
    end

    assign in_handler = (state_q == ST_HANDLER);

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect       <= 1'b0;
            redirect_pc    <= '0;
            info_word      <= '0;
            priv           <= 1'b0;
            saved_priv     <= 1'b0;
            restore_valid  <= 1'b0;
            restore_status <= '0;
        end else begin
            redirect      <= 1'b0;
            restore_valid <= 1'b0;
            unique case (state_q)
                ST_RUN: begin
                    if (cause != CAUSE_NONE) begin
                        info_word      <= pack_word;
                        saved_priv     <= priv;
                        priv           <= 1'b1;
                        restore_status <= status_in;
                        redirect       <= 1'b1;
                        redirect_pc    <= base_q;
                    end else if (prv_load) begin
                        priv <= prv_val;
                    end
                end
                ST_HANDLER: begin
                    if (rfe) begin
                        priv          <= saved_priv;
                        redirect      <= 1'b1;
                        redirect_pc   <= rfe_word[PC_W-1:0];
                        restore_valid <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/wave_trap_chk.sv
module wave_trap_chk #(
    parameter int PC_W = 48,
    parameter int ID_W = 8,
    parameter int RW_W = 6,
    parameter int ST_W = 4,
    localparam int WORD_W = 1 + RW_W + 1 + ID_W + PC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              rfe,
    input logic [WORD_W-1:0] rfe_word,
    input logic              redirect,
    input logic [PC_W-1:0]   redirect_pc,
    input logic [WORD_W-1:0] info_word,
    input logic              priv,
    input logic              in_handler,
    input logic              restore_valid
);
    // R7
    priv_in_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_handler |-> priv);
    // R7
    entry_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_handler) |-> redirect);
    // R10
    return_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_handler) |-> (redirect && restore_valid &&
                               redirect_pc == $past(rfe_word[PC_W-1:0])));
    // R9
    info_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && $past(in_handler)) |-> $stable(info_word));
    // R4
    host_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_handler) && $past(host_req)) |-> info_word[PC_W+ID_W]);
    // R2
    top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        info_word[WORD_W-1] == 1'b0);
    // R11
    rfe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_handler) |-> !restore_valid);
endmodule

bind wave_trap_ctrl wave_trap_chk #(
    .PC_W(PC_W), .ID_W(ID_W), .RW_W(RW_W), .ST_W(ST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .rfe(rfe), .rfe_word(rfe_word),
    .redirect(redirect), .redirect_pc(redirect_pc), .info_word(info_word),
    .priv(priv), .in_handler(in_handler), .restore_valid(restore_valid)
);

// File: tb/sim_wave_trap_ctrl.sv
`timescale 1ns/1ps
module sim_wave_trap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] cur_pc = '0, next_pc = '0, base_wdata = '0;
    logic        instr_done = 0, sw_trap = 0, host_req = 0, step_en = 0;
    logic        prv_load = 0, prv_val = 0, rfe = 0, base_wr = 0;
    logic [7:0]  sw_trap_id = '0;
    logic [5:0]  rewind = '0;
    logic [3:0]  status_in = '0;
    logic [63:0] rfe_word = '0;
    logic        redirect, priv, in_handler, restore_valid;
    logic [47:0] redirect_pc;
    logic [63:0] info_word;
    logic [3:0]  restore_status;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // expected model state
    logic        m_inh = 0, m_priv = 0, m_spriv = 0, m_redir = 0, m_rest = 0;
    logic [47:0] m_base = '0, m_rpc = '0;
    logic [63:0] m_word = '0;
    logic [3:0]  m_stat = '0;

    always #4 clk = ~clk;

    wave_trap_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .next_pc(next_pc),
        .instr_done(instr_done), .sw_trap(sw_trap), .sw_trap_id(sw_trap_id),
        .host_req(host_req), .step_en(step_en), .rewind(rewind),
        .status_in(status_in), .prv_load(prv_load), .prv_val(prv_val),
        .rfe(rfe), .rfe_word(rfe_word), .base_wr(base_wr), .base_wdata(base_wdata),
        .redirect(redirect), .redirect_pc(redirect_pc), .info_word(info_word),
        .priv(priv), .in_handler(in_handler), .restore_valid(restore_valid),
        .restore_status(restore_status)
    );

    function automatic logic [63:0] pack_exp(input bit h, input bit s,
                                             input bit st_fire);
        if (h)            return {1'b0, rewind, 1'b1, 8'h00, next_pc};
        else if (s)       return {1'b0, rewind, 1'b0, sw_trap_id, cur_pc};
        else              return {1'b0, rewind, 1'b0, 8'h00, next_pc};
    endfunction

    task automatic model_step();
        m_redir = 0;
        m_rest  = 0;
        if (!m_inh) begin
            if (host_req || sw_trap || (step_en && instr_done)) begin
                m_word  = pack_exp(host_req, sw_trap, step_en && instr_done);
                m_spriv = m_priv;
                m_priv  = 1;
                m_stat  = status_in;
                m_inh   = 1;
                m_redir = 1;
                m_rpc   = m_base;
            end else if (prv_load) begin
                m_priv = prv_val;
            end
        end else if (rfe) begin
            m_inh   = 0;
            m_priv  = m_spriv;
            m_redir = 1;
            m_rest  = 1;
            m_rpc   = rfe_word[47:0];
        end
        if (base_wr) m_base = base_wdata;
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "redirect", {63'd0, redirect}, {63'd0, m_redir});
        if (m_redir) cmp(tag, "redirect_pc", {16'd0, redirect_pc}, {16'd0, m_rpc});
        cmp(tag, "info_word", info_word, m_word);
        cmp(tag, "priv", {63'd0, priv}, {63'd0, m_priv});
        cmp(tag, "in_handler", {63'd0, in_handler}, {63'd0, m_inh});
        cmp(tag, "restore_valid", {63'd0, restore_valid}, {63'd0, m_rest});
        if (m_rest) cmp(tag, "restore_status", {60'd0, restore_status}, {60'd0, m_stat});
    endtask

    // inputs already set; advance one edge, then compare
    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        #1;
        check_all(tag);
        {instr_done, sw_trap, host_req, step_en, prv_load, rfe, base_wr} = '0;
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        rst_n = 1;
        @(posedge clk);
        #1;
        check_all("R1");

        // R8: write base, R3 software trap with R2 layout
        base_wr = 1; base_wdata = 48'h1234_5678_9ABC;
        tick("R8");
        cur_pc = 48'h8000_0000_4F00; next_pc = 48'h8000_0000_4F04;
        sw_trap = 1; sw_trap_id = 8'h2C; rewind = 6'd5; status_in = 4'hA;
        tick("R3");
        cmp("R2", "word literal", info_word, 64'h0A2C_8000_0000_4F00);
        cmp("R7", "base target", {16'd0, redirect_pc}, {16'd0, 48'h1234_5678_9ABC});

        // R9: requests inside handler ignored
        host_req = 1; sw_trap = 1; step_en = 1; instr_done = 1; sw_trap_id = 8'h77;
        tick("R9");
        tick("R9");

        // R10: return with adjusted pc, junk upper bits
        rfe = 1; rfe_word = {16'hFFFF, 48'h8000_0000_4F04};
        tick("R10");

        // R11: return while running ignored
        rfe = 1; rfe_word = 64'h0000_DEAD_BEEF_0000;
        tick("R11");

        // R12: load privilege, then R4 host trap, R10 restore to 1
        prv_load = 1; prv_val = 1;
        tick("R12");
        host_req = 1; next_pc = 48'h0000_0000_0100; rewind = 6'd63; status_in = 4'h3;
        tick("R4");
        cmp("R4", "host bit", {63'd0, info_word[56]}, 64'd1);
        prv_load = 1; prv_val = 0;
        tick("R12");
        rfe = 1; rfe_word = 64'h100;
        tick("R10");

        // R6: all three causes coincide -> host
        host_req = 1; sw_trap = 1; sw_trap_id = 8'h11; step_en = 1; instr_done = 1;
        tick("R6");
        rfe = 1; tick("R6");
        // software beats step; software with ID 0 still saves cur_pc
        sw_trap = 1; sw_trap_id = 8'h00; step_en = 1; instr_done = 1;
        cur_pc = 48'h0000_0000_0200; next_pc = 48'h0000_0000_0204;
        tick("R6");
        cmp("R3", "id0 saves cur_pc", {16'd0, info_word[47:0]}, 64'h200);
        rfe = 1; tick("R6");

        // R5: step without completion, then with
        step_en = 1; instr_done = 0;
        tick("R5");
        step_en = 1; instr_done = 1; next_pc = 48'h0000_0000_0300;
        tick("R5");
        rfe = 1; tick("R5");

        // R8: base write in the entry cycle uses old base
        base_wr = 1; base_wdata = 48'h0000_00AB_0000; host_req = 1;
        tick("R8");
        rfe = 1; tick("R8");
        host_req = 1;
        tick("R8");
        rfe = 1; tick("R8");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            cur_pc     = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            next_pc    = cur_pc + 48'd4;
            sw_trap_id = 8'($urandom);
            rewind     = 6'($urandom);
            status_in  = 4'($urandom);
            host_req   = ($urandom % 8) == 0;
            sw_trap    = ($urandom % 6) == 0;
            step_en    = ($urandom % 3) == 0;
            instr_done = ($urandom % 2) == 0;
            prv_load   = ($urandom % 5) == 0;
            prv_val    = 1'($urandom);
            rfe        = ($urandom % 3) == 0;
            rfe_word   = {$urandom, $urandom};
            base_wr    = ($urandom % 10) == 0;
            base_wdata = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            tick("R6");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule